// File: doc/BRIEF.md
# DMA Channel Stop Tracking and Interrupt Request

This block follows a single DMA channel from start to stop and decides whether the channel is asking the processor for attention. The transfer engine reports events as single-cycle pulses: the byte counter reached zero, a peripheral signalled it is finished, the source or destination side saw a bus error, the channel setup was found inconsistent, or a breakpoint was hit. From these the block keeps a running/stopped state and a set of sticky status flags. Flags stay set until software clears them.

Software reaches the block through two write strobes. A control write loads three interrupt enables (error, normal completion, breakpoint) and the start bit. Writing the start bit as zero while the channel runs stops it without recording a cause. A flag-clear write removes status flags, one bit per flag, by writing ones. The level interrupt output is the OR of three enable/status pairs, so dropping either side of a pair withdraws that pair's share of the request.

Top module: `dma_halt_irq_ctl`

## Requirements
- R1: After reset, and after any later reset, `running_o`, `enable_o`, `status_o` and `irq_o` are all zero.
- R2: A control write loads `enable_o` from `wr_ctl_data[2:0]` (bit 0 error, bit 1 normal, bit 2 breakpoint). If the channel is stopped and `wr_ctl_data[3]` is one, `running_o` is one after that edge.
- R3: While running, `ev_cnt_zero` sets the done flag (`status_o[0]`) and clears `running_o` at the same edge.
- R4: While running, `ev_periph_done` sets the done flag and stops the channel only when `ev_operand_active` is also high. Without it the strobe changes nothing.
- R5: While running, a control write with bit 3 at zero stops the channel and sets no status flag.
- R6: While running, a source bus error sets only `status_o[1]` and a destination bus error sets only `status_o[2]`. Both stop the channel, and both flags are set if both errors arrive together.
- R7: While running, `ev_cfg_err` sets `status_o[3]` and stops the channel.
- R8: While running, `ev_brkp` sets `status_o[4]` and leaves the channel running.
- R9: While stopped, every event input is ignored and `status_o` does not change.
- R10: Status flags are sticky. A flag-clear write with a one in a bit position clears that flag. If a flag is set and cleared in the same cycle, it ends up set.
- R11: `irq_o` is high exactly when one of these holds: error enable and any of `status_o[3:1]`; normal enable and `status_o[0]`; breakpoint enable and `status_o[4]`. It follows the registered state with no extra cycle.
- R12: Clearing either the enable or the status flag of a pair removes that pair's contribution to `irq_o`.
- R13: If a stop event and a control write with bit 3 at one arrive in the same cycle while the channel runs, the channel stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_ctl_en | input | 1 | Control register write strobe |
| wr_ctl_data | input | 4 | [2:0] enables (error, normal, breakpoint), [3] start |
| wr_clr_en | input | 1 | Flag-clear write strobe |
| wr_clr_data | input | 5 | Write-one-to-clear mask over the status flags |
| ev_cnt_zero | input | 1 | Byte counter reached zero |
| ev_periph_done | input | 1 | Peripheral done strobe |
| ev_operand_active | input | 1 | An operand transfer is in progress |
| ev_berr_src | input | 1 | Bus error on a source cycle |
| ev_berr_dst | input | 1 | Bus error on a destination cycle |
| ev_cfg_err | input | 1 | Configuration error detected |
| ev_brkp | input | 1 | Breakpoint hit |
| running_o | output | 1 | Channel running state |
| enable_o | output | 3 | Interrupt enables: [0] error, [1] normal, [2] breakpoint |
| status_o | output | 5 | Flags: [0] done, [1] source bus error, [2] destination bus error, [3] configuration error, [4] breakpoint |
| irq_o | output | 1 | Level interrupt request |

## Verification
Every event and every write is sampled at one clock edge. Its effect on `running_o`, `enable_o` and `status_o` is visible right after that same edge. `irq_o` is combinational from the registered state, so it changes in that same cycle with no added delay. The bench drives each stimulus for exactly one cycle, waits for one rising edge, and samples one time unit later. It then takes the inputs away, so every check looks at the result of exactly one edge.

// File: rtl/dmaterm_pkg.sv
package dmaterm_pkg;
    localparam int FLAG_W  = 5;
    localparam int FL_DONE = 0;
    localparam int FL_BSRC = 1;
    localparam int FL_BDST = 2;
    localparam int FL_CFG  = 3;
    localparam int FL_BRK  = 4;

    localparam int PAIR_N  = 3;
    localparam int PR_ERR  = 0;
    localparam int PR_NORM = 1;
    localparam int PR_BRK  = 2;

    localparam int CTL_W   = PAIR_N + 1;
    localparam int CTL_RUN = PAIR_N;

    typedef struct packed {
        logic              running;
        logic [PAIR_N-1:0] en;
        logic [FLAG_W-1:0] status;
    } term_state_t;

    // status bits that feed each interrupt pair
    function automatic logic [FLAG_W-1:0] pair_mask(input int p);
        logic [FLAG_W-1:0] m;
        m = '0;
        case (p)
            PR_ERR:  begin m[FL_BSRC] = 1'b1; m[FL_BDST] = 1'b1; m[FL_CFG] = 1'b1; end
            PR_NORM: m[FL_DONE] = 1'b1;
            PR_BRK:  m[FL_BRK]  = 1'b1;
            default: m = '0;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/term_event_decode.sv
module term_event_decode
    import dmaterm_pkg::*;
(
    input  logic              running,
    input  logic              ev_cnt_zero,
    input  logic              ev_periph_done,
    input  logic              ev_operand_active,
    input  logic              ev_berr_src,
    input  logic              ev_berr_dst,
    input  logic              ev_cfg_err,
    input  logic              ev_brkp,
    output logic [FLAG_W-1:0] set_mask,
    output logic              stop_req
);
    logic done_hit;

    always_comb begin
        done_hit = ev_cnt_zero | (ev_periph_done & ev_operand_active);
        set_mask = '0;
        stop_req = 1'b0;
        if (running) begin
            set_mask[FL_DONE] = done_hit;
            set_mask[FL_BSRC] = ev_berr_src;
            set_mask[FL_BDST] = ev_berr_dst;
            set_mask[FL_CFG]  = ev_cfg_err;
            set_mask[FL_BRK]  = ev_brkp;
            // a breakpoint is reported but does not halt the channel
            stop_req = done_hit | ev_berr_src | ev_berr_dst | ev_cfg_err;
        end
    end
endmodule

// File: rtl/term_state.sv
module term_state
    import dmaterm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctl_en,
    input  logic [CTL_W-1:0]  wr_ctl_data,
    input  logic              wr_clr_en,
    input  logic [FLAG_W-1:0] wr_clr_data,
    input  logic [FLAG_W-1:0] set_mask,
    input  logic              stop_req,
    output logic              running,
    output logic [PAIR_N-1:0] en,
    output logic [FLAG_W-1:0] status
);
    term_state_t st_d, st_q;
    logic [FLAG_W-1:0] clr_mask;

    always_comb begin
        st_d     = st_q;
        clr_mask = wr_clr_en ? wr_clr_data : '0;
        if (wr_ctl_en) begin
            st_d.en = wr_ctl_data[PAIR_N-1:0];
            if (!st_q.running)
                st_d.running = wr_ctl_data[CTL_RUN];
            else if (!wr_ctl_data[CTL_RUN])
                st_d.running = 1'b0;
        end
        // new events win over a clear in the same cycle
        st_d.status = (st_q.status & ~clr_mask) | set_mask;
        if (stop_req)
            st_d.running = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign running = st_q.running;
    assign en      = st_q.en;
    assign status  = st_q.status;

    // R10: a flag stays set unless its bit was cleared
    p_sticky_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & ($past(status) & ~$past(clr_mask))) ==
                  ($past(status) & ~$past(clr_mask))))
        else $error("p_sticky_flags_r10");

    // R2: a start write on a stopped channel starts it
    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && wr_ctl_en && wr_ctl_data[CTL_RUN]) |=> running)
        else $error("p_start_r2");
endmodule

// File: rtl/term_irq_merge.sv
module term_irq_merge
    import dmaterm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PAIR_N-1:0] en,
    input  logic [FLAG_W-1:0] status,
    output logic              irq
);
    logic [PAIR_N-1:0] pair_hit;

    for (genvar p = 0; p < PAIR_N; p++) begin : g_pair
        localparam logic [FLAG_W-1:0] MASK = pair_mask(p);
        assign pair_hit[p] = en[p] & (|(status & MASK));
    end

    assign irq = |pair_hit;

    // R12: no request without an enable
    p_irq_needs_enable_r12: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (en != '0))
        else $error("p_irq_needs_enable_r12");

    // R11: no request without a status flag
    p_irq_needs_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status != '0))
        else $error("p_irq_needs_flag_r11");
endmodule

// File: rtl/dma_halt_irq_ctl.sv
module dma_halt_irq_ctl
    import dmaterm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctl_en,
    input  logic [3:0]        wr_ctl_data,
    input  logic              wr_clr_en,
    input  logic [4:0]        wr_clr_data,
    input  logic              ev_cnt_zero,
    input  logic              ev_periph_done,
    input  logic              ev_operand_active,
    input  logic              ev_berr_src,
    input  logic              ev_berr_dst,
    input  logic              ev_cfg_err,
    input  logic              ev_brkp,
    output logic              running_o,
    output logic [2:0]        enable_o,
    output logic [4:0]        status_o,
    output logic              irq_o
);
    logic [FLAG_W-1:0] set_mask;
    logic              stop_req;

    term_event_decode u_decode (
        .running          (running_o),
        .ev_cnt_zero      (ev_cnt_zero),
        .ev_periph_done   (ev_periph_done),
        .ev_operand_active(ev_operand_active),
        .ev_berr_src      (ev_berr_src),
        .ev_berr_dst      (ev_berr_dst),
        .ev_cfg_err       (ev_cfg_err),
        .ev_brkp          (ev_brkp),
        .set_mask         (set_mask),
        .stop_req         (stop_req)
    );

    term_state u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ctl_en  (wr_ctl_en),
        .wr_ctl_data(wr_ctl_data),
        .wr_clr_en  (wr_clr_en),
        .wr_clr_data(wr_clr_data),
        .set_mask   (set_mask),
        .stop_req   (stop_req),
        .running    (running_o),
        .en         (enable_o),
        .status     (status_o)
    );

    term_irq_merge u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (enable_o),
        .status(status_o),
        .irq   (irq_o)
    );

    // R3: counter exhaustion halts and records done
    p_cnt_zero_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (running_o && ev_cnt_zero) |=> (!running_o && status_o[FL_DONE]))
        else $error("p_cnt_zero_stop_r3");

    // R5: a software stop halts the channel
    p_sw_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (running_o && wr_ctl_en && !wr_ctl_data[CTL_RUN]) |=> !running_o)
        else $error("p_sw_stop_r5");

    // R6, R13: a source bus error halts, even against a start write
    p_berr_src_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (running_o && ev_berr_src) |=> (!running_o && status_o[FL_BSRC]))
        else $error("p_berr_src_stop_r6");

    // R8: a lone breakpoint keeps the channel running
    p_brk_keeps_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (running_o && ev_brkp && !ev_cnt_zero && !(ev_periph_done && ev_operand_active)
         && !ev_berr_src && !ev_berr_dst && !ev_cfg_err
         && !(wr_ctl_en && !wr_ctl_data[CTL_RUN])) |=> running_o)
        else $error("p_brk_keeps_run_r8");

    // R9: a stopped channel gains no flags
    p_stopped_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!running_o && !wr_clr_en) |=> (status_o == $past(status_o)))
        else $error("p_stopped_quiet_r9");
endmodule

// File: tb/test_dma_halt_irq_ctl.sv
module test_dma_halt_irq_ctl;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_ctl_en;
    logic [3:0] wr_ctl_data;
    logic       wr_clr_en;
    logic [4:0] wr_clr_data;
    logic       ev_cnt_zero, ev_periph_done, ev_operand_active;
    logic       ev_berr_src, ev_berr_dst, ev_cfg_err, ev_brkp;
    logic       running_o;
    logic [2:0] enable_o;
    logic [4:0] status_o;
    logic       irq_o;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    dma_halt_irq_ctl i_dma_halt_irq_ctl (
        .clk(clk), .rst_n(rst_n),
        .wr_ctl_en(wr_ctl_en), .wr_ctl_data(wr_ctl_data),
        .wr_clr_en(wr_clr_en), .wr_clr_data(wr_clr_data),
        .ev_cnt_zero(ev_cnt_zero), .ev_periph_done(ev_periph_done),
        .ev_operand_active(ev_operand_active),
        .ev_berr_src(ev_berr_src), .ev_berr_dst(ev_berr_dst),
        .ev_cfg_err(ev_cfg_err), .ev_brkp(ev_brkp),
        .running_o(running_o), .enable_o(enable_o),
        .status_o(status_o), .irq_o(irq_o)
    );

    task automatic chk(input string req, input string what, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic idle();
        wr_ctl_en = 0; wr_ctl_data = 0; wr_clr_en = 0; wr_clr_data = 0;
        ev_cnt_zero = 0; ev_periph_done = 0; ev_operand_active = 0;
        ev_berr_src = 0; ev_berr_dst = 0; ev_cfg_err = 0; ev_brkp = 0;
    endtask

    // one rising edge, then sample 1 ns later and drop the stimulus
    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic apply();
        step();
        idle();
    endtask

    task automatic ctl(input logic run, input logic [2:0] en);
        wr_ctl_en = 1; wr_ctl_data = {run, en};
        apply();
    endtask

    task automatic clr(input logic [4:0] m);
        wr_clr_en = 1; wr_clr_data = m;
        apply();
    endtask

    task automatic do_reset();
        rst_n = 0; idle();
        step(); step();
        rst_n = 1;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", "running", running_o, 0);
        chk("R1", "enable", enable_o, 0);
        chk("R1", "status", status_o, 0);
        chk("R1", "irq", irq_o, 0);
    endtask

    task automatic t_start();
        ctl(1'b1, 3'b011);
        chk("R2", "running after start", running_o, 1);
        chk("R2", "enable loaded", enable_o, 3);
    endtask

    task automatic t_cnt_zero();
        ctl(1'b1, 3'b010);
        ev_cnt_zero = 1; apply();
        chk("R3", "running after zero", running_o, 0);
        chk("R3", "status done", status_o, 1);
        chk("R11", "irq normal pair", irq_o, 1);
        clr(5'b00001);
        chk("R10", "done cleared", status_o, 0);
        chk("R12", "irq after flag clear", irq_o, 0);
    endtask

    task automatic t_periph_done();
        ctl(1'b1, 3'b010);
        ev_periph_done = 1; ev_operand_active = 0; apply();
        chk("R4", "ignored done keeps run", running_o, 1);
        chk("R4", "ignored done no flag", status_o, 0);
        ev_periph_done = 1; ev_operand_active = 1; apply();
        chk("R4", "done during operand stops", running_o, 0);
        chk("R4", "done flag", status_o, 1);
        clr(5'b11111);
    endtask

    task automatic t_sw_stop();
        ctl(1'b1, 3'b111);
        ctl(1'b0, 3'b111);
        chk("R5", "software stop", running_o, 0);
        chk("R5", "no flag", status_o, 0);
        chk("R5", "no irq", irq_o, 0);
    endtask

    task automatic t_berr();
        ctl(1'b1, 3'b001);
        ev_berr_src = 1; apply();
        chk("R6", "src stop", running_o, 0);
        chk("R6", "src flag only", status_o, 2);
        chk("R11", "irq error pair", irq_o, 1);
        ctl(1'b0, 3'b000);
        chk("R12", "irq after enable clear", irq_o, 0);
        chk("R10", "flag kept after enable clear", status_o, 2);
        clr(5'b00010);
        ctl(1'b1, 3'b001);
        ev_berr_dst = 1; apply();
        chk("R6", "dst flag only", status_o, 4);
        chk("R6", "dst stop", running_o, 0);
        clr(5'b00100);
        ctl(1'b1, 3'b001);
        ev_berr_src = 1; ev_berr_dst = 1; apply();
        chk("R6", "both flags", status_o, 6);
        clr(5'b11111);
        chk("R12", "irq after all clear", irq_o, 0);
    endtask

    task automatic t_cfg();
        ctl(1'b1, 3'b001);
        ev_cfg_err = 1; apply();
        chk("R7", "cfg flag", status_o, 8);
        chk("R7", "cfg stop", running_o, 0);
        chk("R11", "irq cfg", irq_o, 1);
        clr(5'b01000);
    endtask

    task automatic t_brk();
        ctl(1'b1, 3'b100);
        ev_brkp = 1; apply();
        chk("R8", "brk flag", status_o, 16);
        chk("R8", "still running", running_o, 1);
        chk("R11", "irq brk", irq_o, 1);
        ctl(1'b1, 3'b000);
        chk("R12", "irq after brk enable clear", irq_o, 0);
        ctl(1'b0, 3'b000);
        clr(5'b10000);
    endtask

    task automatic t_stopped_ignore();
        ctl(1'b0, 3'b111);
        ev_cnt_zero = 1; ev_periph_done = 1; ev_operand_active = 1;
        ev_berr_src = 1; ev_berr_dst = 1; ev_cfg_err = 1; ev_brkp = 1;
        apply();
        chk("R9", "no flags when stopped", status_o, 0);
        chk("R9", "stays stopped", running_o, 0);
        chk("R9", "no irq", irq_o, 0);
    endtask

    task automatic t_set_vs_clear();
        ctl(1'b1, 3'b000);
        ev_cnt_zero = 1; wr_clr_en = 1; wr_clr_data = 5'b00001; apply();
        chk("R10", "set beats clear", status_o, 1);
        clr(5'b00001);
    endtask

    task automatic t_stop_wins();
        ctl(1'b1, 3'b000);
        ev_berr_src = 1; wr_ctl_en = 1; wr_ctl_data = 4'b1000; apply();
        chk("R13", "stop beats start write", running_o, 0);
        chk("R13", "flag set", status_o, 2);
    endtask

    task automatic t_reset_mid();
        ctl(1'b1, 3'b111);
        ev_brkp = 1; apply();
        do_reset();
        chk("R1", "running after late reset", running_o, 0);
        chk("R1", "status after late reset", status_o, 0);
        chk("R1", "enable after late reset", enable_o, 0);
        chk("R1", "irq after late reset", irq_o, 0);
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_start();
        t_cnt_zero();
        t_periph_done();
        t_sw_stop();
        t_berr();
        t_cfg();
        t_brk();
        t_stopped_ignore();
        t_set_vs_clear();
        t_stop_wins();
        t_reset_mid();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule